// File: doc/BRIEF.md
# Sixteen-Bit Execute ALU with Shifter and Condition Flags

This block is the execute stage for a small 16-bit processor. Each cycle in which `valid` is high, it takes a decoded operation code, a source operand and a destination operand. It then computes a logic, arithmetic, single-bit or shift result. It updates a zero flag and a negative flag, which later conditional branches (equal, not equal, minus, plus) read. The source operand arrives already chosen by the operand-fetch stage, whether a register or the program counter. Optionally, a short immediate replaces it, and the block zero-extends that immediate itself.

Result, write-enable and flags are registered. An operation sampled at a rising edge shows its outputs from that edge onward. Writeback routing and operand fetch are outside this block. Some operations only set flags and never raise the write-enable: compare, test and bit test.

Top module: `exec_alu_unit`

## Requirements
- R1: While `rstN` is low, `result` is 0, `wrEn` is 0, and both `flagZ` and `flagN` are 0.
- R2: An operation with `valid` high at a rising edge updates the outputs at that same edge. `wrEn` is high for exactly the one cycle after a valid writing operation and low otherwise.
- R3: Logic codes (4-bit `opCode`): 0 gives dst OR src, 1 gives dst AND src, 2 gives dst XOR src, 4 copies src. Each of them writes back.
- R4: Code 5 gives dst + src and code 6 gives dst − src, both modulo 2^16, and both write back.
- R5: Code 7 (compare, dst − src) and code 3 (test, dst AND src) set the flags from their value. They keep `wrEn` low and leave `result` at its prior value.
- R6: When `useImm` is 1, the operand is `immVal` (5 bits) zero-extended to 16 bits in place of `srcOperand`. Shifts and bit operations use only its low 4 bits, so bit 4 of `immVal` has no effect on them.
- R7: A register shift amount or bit index uses only bits 3:0 of `srcOperand`.
- R8: Code 10 is a logical left shift, code 11 a logical right shift with zero fill, and code 12 an arithmetic right shift that copies bit 15. All three write back.
- R9: Code 8 (bit test) sets `flagZ` when bit `index` of dst is 0 and clears it otherwise. It leaves `flagN` unchanged and keeps `wrEn` low.
- R10: Code 9 (bit clear) writes dst with bit `index` forced to 0.
- R11: Every operation other than bit test that updates flags sets `flagZ` when its 16-bit value is zero and sets `flagN` to bit 15 of that value.
- R12: Flags keep their value on cycles with `valid` low. Codes 13 to 15 are no-ops: no write and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| valid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Decoded operation code |
| useImm | input | 1 | Select zero-extended immediate as operand |
| srcOperand | input | 16 | Source operand (register or program counter) |
| immVal | input | 5 | Short immediate |
| dstOperand | input | 16 | Destination register value |
| result | output | 16 | Registered result for writeback |
| wrEn | output | 1 | Destination write strobe |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |

## Verification
The arithmetic ops run with operands that wrap through zero and cross the sign bit, so a carry or borrow slip shows in both the value and the flags. The shifts use a negative operand at amounts 0, 1 and 15. That pattern tells the zero fill of a logical shift apart from the sign fill of an arithmetic one, and it exposes an off-by-one in the shifter stages. Bit test and bit clear probe both end bits, bit 0 and bit 15. A register operand with its upper bits set and an immediate with bit 4 set show whether the index is cut to four bits. Idle cycles and the unused codes run with changing operands to show that the flags and the write strobe stay put.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

  typedef enum logic [3:0] {
    OPC_OR   = 4'd0,
    OPC_AND  = 4'd1,
    OPC_XOR  = 4'd2,
    OPC_TST  = 4'd3,
    OPC_MOV  = 4'd4,
    OPC_ADD  = 4'd5,
    OPC_SUB  = 4'd6,
    OPC_CMP  = 4'd7,
    OPC_BTST = 4'd8,
    OPC_BCLR = 4'd9,
    OPC_SHL  = 4'd10,
    OPC_SHR  = 4'd11,
    OPC_SAR  = 4'd12
  } opc_e;

  typedef enum logic [3:0] {
    FN_OR, FN_AND, FN_XOR, FN_PASS, FN_ADD, FN_SUB,
    FN_BTST, FN_BCLR, FN_SHL, FN_SHR, FN_SAR
  } fn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doWrite;   // result goes to destination
    logic setZN;     // Z and N from computed value
    logic setZOnly;  // Z from tested bit, N kept
    fn_e  fn;
  } strobe_t;

endpackage

// File: rtl/exec_alu_ctrl.sv
module exec_alu_ctrl
  import exec_alu_pkg::*;
(
  input  logic [3:0] opCode,
  output strobe_t    strobe
);

  always_comb begin
    strobe = '0;
    case (opCode)
      OPC_OR:   begin strobe.fn = FN_OR;   strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_AND:  begin strobe.fn = FN_AND;  strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_XOR:  begin strobe.fn = FN_XOR;  strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_TST:  begin strobe.fn = FN_AND;  strobe.setZN = 1'b1; end
      OPC_MOV:  begin strobe.fn = FN_PASS; strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_ADD:  begin strobe.fn = FN_ADD;  strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_SUB:  begin strobe.fn = FN_SUB;  strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_CMP:  begin strobe.fn = FN_SUB;  strobe.setZN = 1'b1; end
      OPC_BTST: begin strobe.fn = FN_BTST; strobe.setZOnly = 1'b1; end
      OPC_BCLR: begin strobe.fn = FN_BCLR; strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_SHL:  begin strobe.fn = FN_SHL;  strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_SHR:  begin strobe.fn = FN_SHR;  strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      OPC_SAR:  begin strobe.fn = FN_SAR;  strobe.doWrite = 1'b1; strobe.setZN = 1'b1; end
      default:  strobe = '0;
    endcase
  end

endmodule

// File: rtl/exec_alu_shift.sv
module exec_alu_shift #(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  amt,
  input  logic              toLeft,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic              fillBit;
  logic [DATA_W-1:0] stage [IDX_W+1];

  // left shifts run through the right-shift barrel on a bit-reversed word
  assign fillBit  = arith & ~toLeft & din[DATA_W-1];
  assign stage[0] = toLeft ? flip(din) : din;

  for (genvar k = 0; k < IDX_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {{SH{fillBit}}, stage[k][DATA_W-1:SH]} : stage[k];
  end

  assign dout = toLeft ? flip(stage[IDX_W]) : stage[IDX_W];

endmodule

// File: rtl/exec_alu_dp.sv
module exec_alu_dp
  import exec_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  strobe_t           strobe,
  input  logic              useImm,
  input  logic [DATA_W-1:0] srcOperand,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [DATA_W-1:0] dstOperand,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              flagZ,
  output logic              flagN
);

  logic [DATA_W-1:0] opB;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] shiftOut;
  logic [DATA_W-1:0] valNext;
  logic              testedBit;
  logic              isLeft;
  logic              isArith;

  assign opB       = useImm ? {{(DATA_W-IMM_W){1'b0}}, immVal} : srcOperand;
  assign bitIdx    = opB[IDX_W-1:0];
  assign bitMask   = {{(DATA_W-1){1'b0}}, 1'b1} << bitIdx;
  assign testedBit = dstOperand[bitIdx];
  assign isLeft    = (strobe.fn == FN_SHL);
  assign isArith   = (strobe.fn == FN_SAR);

  exec_alu_shift #(.DATA_W(DATA_W)) shift_i (
    .din    (dstOperand),
    .amt    (bitIdx),
    .toLeft (isLeft),
    .arith  (isArith),
    .dout   (shiftOut)
  );

  always_comb begin
    case (strobe.fn)
      FN_OR:   valNext = dstOperand | opB;
      FN_AND:  valNext = dstOperand & opB;
      FN_XOR:  valNext = dstOperand ^ opB;
      FN_PASS: valNext = opB;
      FN_ADD:  valNext = dstOperand + opB;
      FN_SUB:  valNext = dstOperand - opB;
      FN_BCLR: valNext = dstOperand & ~bitMask;
      FN_SHL,
      FN_SHR,
      FN_SAR:  valNext = shiftOut;
      default: valNext = dstOperand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      wrEn   <= 1'b0;
      flagZ  <= 1'b0;
      flagN  <= 1'b0;
    end else begin
      wrEn <= valid & strobe.doWrite;
      if (valid && strobe.doWrite) result <= valNext;
      if (valid && strobe.setZN) begin
        flagZ <= (valNext == '0);
        flagN <= valNext[DATA_W-1];
      end else if (valid && strobe.setZOnly) begin
        flagZ <= ~testedBit;
      end
    end
  end

endmodule

// File: rtl/exec_alu_unit.sv
module exec_alu_unit
  import exec_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [3:0]        opCode,
  input  logic              useImm,
  input  logic [DATA_W-1:0] srcOperand,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [DATA_W-1:0] dstOperand,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              flagZ,
  output logic              flagN
);

  strobe_t strobe;

  exec_alu_ctrl ctrl_i (
    .opCode (opCode),
    .strobe (strobe)
  );

  exec_alu_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .valid      (valid),
    .strobe     (strobe),
    .useImm     (useImm),
    .srcOperand (srcOperand),
    .immVal     (immVal),
    .dstOperand (dstOperand),
    .result     (result),
    .wrEn       (wrEn),
    .flagZ      (flagZ),
    .flagN      (flagN)
  );

endmodule

// File: rtl/exec_alu_chk.sv
module exec_alu_chk #(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              valid,
  input logic [3:0]        opCode,
  input logic              useImm,
  input logic [IDX_W-1:0]  srcIdx,
  input logic [IDX_W-1:0]  immIdx,
  input logic [DATA_W-1:0] dstOperand,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              flagZ,
  input logic              flagN
);

  logic [IDX_W-1:0] idxNow;
  logic             bitNow;
  logic             flagOnlyOp;

  assign idxNow     = useImm ? immIdx : srcIdx;
  assign bitNow     = dstOperand[idxNow];
  assign flagOnlyOp = (opCode == 4'd3) || (opCode == 4'd7) || (opCode == 4'd8);

  AST_WREN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(valid)); // R2
  AST_FLAGONLY_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (valid && flagOnlyOp) |=> !wrEn); // R5
  AST_ZN_TRACK_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((flagZ == (result == '0)) && (flagN == result[DATA_W-1]))); // R11
  AST_BTST_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opCode == 4'd8) |=> (flagZ == !$past(bitNow))); // R9
  AST_BTST_KEEP_N: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opCode == 4'd8) |=> $stable(flagN)); // R9
  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> ($stable(flagZ) && $stable(flagN) && !wrEn)); // R12
  AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opCode > 4'd12) |=> ($stable(flagZ) && $stable(flagN) && !wrEn)); // R12

endmodule

bind exec_alu_unit exec_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .valid      (valid),
  .opCode     (opCode),
  .useImm     (useImm),
  .srcIdx     (srcOperand[$clog2(DATA_W)-1:0]),
  .immIdx     (immVal[$clog2(DATA_W)-1:0]),
  .dstOperand (dstOperand),
  .result     (result),
  .wrEn       (wrEn),
  .flagZ      (flagZ),
  .flagN      (flagN)
);

// File: tb/exec_alu_unit_tb_top.sv
`timescale 1ns/1ps
module exec_alu_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic        useImm = 1'b0;
  logic [15:0] srcOperand = 16'h0;
  logic [4:0]  immVal = 5'h0;
  logic [15:0] dstOperand = 16'h0;
  logic [15:0] result;
  logic        wrEn;
  logic        flagZ;
  logic        flagN;

  int checks = 0;
  int errors = 0;
  logic [15:0] mRes = 16'h0;
  logic        mZ = 1'b0;
  logic        mN = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  exec_alu_unit dut_i (
    .clk(clk), .rstN(rstN), .valid(valid), .opCode(opCode), .useImm(useImm),
    .srcOperand(srcOperand), .immVal(immVal), .dstOperand(dstOperand),
    .result(result), .wrEn(wrEn), .flagZ(flagZ), .flagN(flagN)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // issue one operation at a falling edge, check after the next rising edge
  task automatic doOp(input string tag, input logic [3:0] op, input logic ui,
                      input logic [15:0] src, input logic [4:0] imm, input logic [15:0] dst);
    logic [15:0] b;
    logic [3:0]  amt;
    logic [15:0] v;
    logic        w;
    logic        zn;
    b  = ui ? {11'h0, imm} : src;
    amt = b[3:0];
    w  = 1'b0; zn = 1'b0; v = 16'h0;
    case (op)
      4'd0:  begin v = dst | b; w = 1; zn = 1; end
      4'd1:  begin v = dst & b; w = 1; zn = 1; end
      4'd2:  begin v = dst ^ b; w = 1; zn = 1; end
      4'd3:  begin v = dst & b; zn = 1; end
      4'd4:  begin v = b; w = 1; zn = 1; end
      4'd5:  begin v = dst + b; w = 1; zn = 1; end
      4'd6:  begin v = dst - b; w = 1; zn = 1; end
      4'd7:  begin v = dst - b; zn = 1; end
      4'd8:  mZ = ~dst[amt];
      4'd9:  begin v = dst & ~(16'h1 << amt); w = 1; zn = 1; end
      4'd10: begin v = dst << amt; w = 1; zn = 1; end
      4'd11: begin v = dst >> amt; w = 1; zn = 1; end
      4'd12: begin v = 16'($signed(dst) >>> amt); w = 1; zn = 1; end
      default: ;
    endcase
    if (w) mRes = v;
    if (zn) begin mZ = (v == 16'h0); mN = v[15]; end
    valid = 1'b1; opCode = op; useImm = ui; srcOperand = src; immVal = imm; dstOperand = dst;
    @(negedge clk);
    valid = 1'b0;
    chk(tag, "result", result, mRes);
    chk(tag, "wrEn", {15'h0, wrEn}, {15'h0, w});
    chk(tag, "flagZ", {15'h0, flagZ}, {15'h0, mZ});
    chk(tag, "flagN", {15'h0, flagN}, {15'h0, mN});
  endtask

  task automatic testReset;
    chk("R1", "result", result, 16'h0);
    chk("R1", "wrEn", {15'h0, wrEn}, 16'h0);
    chk("R1", "flagZ", {15'h0, flagZ}, 16'h0);
    chk("R1", "flagN", {15'h0, flagN}, 16'h0);
  endtask

  task automatic testLogic;
    doOp("R3", 4'd0, 0, 16'h00F0, 5'h0, 16'h0F00);
    doOp("R3", 4'd1, 0, 16'h00F0, 5'h0, 16'h0F00);
    doOp("R3", 4'd2, 0, 16'hFFFF, 5'h0, 16'h7FFF);
    doOp("R3", 4'd4, 0, 16'hA5A5, 5'h0, 16'h0000);
    doOp("R2", 4'd4, 0, 16'h0000, 5'h0, 16'h1234);
  endtask

  task automatic testArith;
    doOp("R4", 4'd5, 0, 16'h0001, 5'h0, 16'hFFFF);
    doOp("R4", 4'd5, 0, 16'h0001, 5'h0, 16'h7FFF);
    doOp("R4", 4'd6, 0, 16'h0003, 5'h0, 16'h0001);
    doOp("R11", 4'd6, 0, 16'h1234, 5'h0, 16'h1234);
  endtask

  task automatic testFlagOnly;
    doOp("R5", 4'd7, 0, 16'h0005, 5'h0, 16'h0005);
    doOp("R5", 4'd7, 0, 16'h0006, 5'h0, 16'h0005);
    doOp("R5", 4'd3, 0, 16'h8000, 5'h0, 16'hFFFF);
    doOp("R5", 4'd3, 0, 16'h00FF, 5'h0, 16'hFF00);
  endtask

  task automatic testImm;
    doOp("R6", 4'd4, 1, 16'hFFFF, 5'h1F, 16'h0000);
    doOp("R6", 4'd5, 1, 16'h0000, 5'h10, 16'h0001);
    doOp("R6", 4'd10, 1, 16'hFFFF, 5'h13, 16'h0001);
    doOp("R6", 4'd8, 1, 16'h0000, 5'h12, 16'h0004);
  endtask

  task automatic testShifts;
    doOp("R8", 4'd10, 0, 16'h0001, 5'h0, 16'h8001);
    doOp("R8", 4'd11, 0, 16'h0001, 5'h0, 16'h8001);
    doOp("R8", 4'd12, 0, 16'h0001, 5'h0, 16'h8001);
    doOp("R8", 4'd12, 0, 16'h000F, 5'h0, 16'h8000);
    doOp("R8", 4'd11, 0, 16'h000F, 5'h0, 16'h8000);
    doOp("R8", 4'd12, 0, 16'h0000, 5'h0, 16'h9234);
    doOp("R7", 4'd11, 0, 16'hFFF4, 5'h0, 16'hF000);
    doOp("R7", 4'd10, 0, 16'h0010, 5'h0, 16'h1234);
  endtask

  task automatic testBits;
    doOp("R9", 4'd4, 0, 16'h8000, 5'h0, 16'h0000);
    doOp("R9", 4'd8, 0, 16'h0000, 5'h0, 16'h0001);
    doOp("R9", 4'd8, 0, 16'h000F, 5'h0, 16'h7FFF);
    doOp("R9", 4'd8, 0, 16'h001F, 5'h0, 16'h8000);
    doOp("R10", 4'd9, 0, 16'h000F, 5'h0, 16'hFFFF);
    doOp("R10", 4'd9, 0, 16'h0000, 5'h0, 16'h0001);
    doOp("R10", 4'd9, 1, 16'h0000, 5'h13, 16'h000F);
  endtask

  task automatic testHold;
    doOp("R12", 4'd6, 0, 16'h0001, 5'h0, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      opCode = 4'd4; srcOperand = 16'h0000; dstOperand = 16'h0000 + 16'(i);
      @(negedge clk);
      chk("R12", "idle wrEn", {15'h0, wrEn}, 16'h0);
      chk("R12", "idle flagZ", {15'h0, flagZ}, {15'h0, mZ});
      chk("R12", "idle flagN", {15'h0, flagN}, {15'h0, mN});
    end
    doOp("R12", 4'd13, 0, 16'h0000, 5'h0, 16'h0000);
    doOp("R12", 4'd14, 1, 16'h0000, 5'h0, 16'h0000);
    doOp("R12", 4'd15, 0, 16'h8000, 5'h0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testLogic();
    testArith();
    testFlagOnly();
    testImm();
    testShifts();
    testBits();
    testHold();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule